// File: doc/BRIEF.md
# Word-Serial Configuration Register Loader

This block loads the setup storage of a filter engine over a 12-bit word bus. Each access opens with one address word. The top nibble of that word names the kind of storage and the low byte names the entry. A fixed number of data words then follows, and that number depends on the kind. The words collect in a staging buffer. Only when the last word of the group has arrived does the loader issue a single write strobe, together with the kind, the entry index and the fully assembled value.

An active-low load enable brackets each burst. While it is high the bus is ignored. If it is raised in the middle of a group, the words collected so far are thrown away. Groups may follow one another with no gap: the word after a group's last data word is always taken as a new address. An address whose kind nibble is not recognised raises a one-cycle error pulse. The loader then ignores the bus until the load enable goes high again.

Top module: `cfg_word_loader`

## Requirements
- R1: After reset, `wr_stb` and `err_stb` are 0 and `wr_kind`, `wr_index` and `wr_data` are all zero.
- R2: Address word bits [11:8] select the kind and bits [7:0] give the index. The encodings are 1h coefficient bank (wr_kind 2), 8h round (4), Ch limit (5), 4h select (3) and 0h configuration (1). C07h therefore addresses limit entry 7.
- R3: The group lengths in data words are 8 for a coefficient bank, 4 for round, 4 for limit and 1 for select or configuration. `wr_stb` is high for exactly the one cycle after the clock edge that latches the last data word.
- R4: For a coefficient bank, data word k (k = 0..7) lands in `wr_data[12k+11:12k]`.
- R5: For a round entry, bits [7:0] of data word k (k = 0..3) land in `wr_data[8k+7:8k]`, giving a 32-bit value sent least significant byte first. Bits [95:32] are zero.
- R6: For a limit entry, data words 0 and 1 form the lower limit in `wr_data[15:0]`, low byte first. Data words 2 and 3 form the upper limit in `wr_data[31:16]`, also low byte first. For example, 060h, 03Bh, 0A4h, 072h gives 72A43B60h.
- R7: For select and configuration entries, the single data word appears in `wr_data[11:0]` and the rest is zero.
- R8: Bits [11:8] of round and limit data words have no effect on `wr_data`.
- R9: The word that follows the last data word of a group, with the load enable still low, is decoded as a new address.
- R10: While `ld_n` is high, the bus is ignored and no strobe is issued. Raising `ld_n` before a group is complete discards that group without any write.
- R11: An address with any other kind nibble pulses `err_stb` for one cycle, one cycle after it is latched. Later bus words cause no write and no error until `ld_n` has been high for at least one cycle.
- R12: `wr_stb` stays low while the data words of a group other than the last are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Load enable, active low |
| bus_word | input | 12 | Address or data word |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_kind | output | 3 | Kind of the committed entry |
| wr_index | output | 8 | Index of the committed entry |
| wr_data | output | 96 | Assembled value |
| err_stb | output | 1 | Unknown-kind address pulse |

## Verification
Directed groups with known values fix the byte and word packing of each kind. This separates the 12-bit word placement of coefficient banks from the byte placement of round and limit entries. Random groups of random kinds are sent back to back, with random reserved nibbles and occasional idle gaps, and they show that group lengths and address realignment are kept over long runs. Aborted groups, unknown kinds followed by data, and idle cycles carrying noise on the bus show that partial or rejected input never produces a write and never leaks into the next group.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  parameter int WORD_W  = 12;
  parameter int BYTE_W  = 8;
  parameter int TAPS    = 8;
  parameter int IDX_W   = 8;
  parameter int CODE_W  = 4;
  parameter int BYTE_GRP = 4;
  parameter int DATA_W  = TAPS * WORD_W;
  parameter int CNT_W   = $clog2(TAPS);

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_CONFIG = 3'd1,
    K_COEF   = 3'd2,
    K_SELECT = 3'd3,
    K_ROUND  = 3'd4,
    K_LIMIT  = 3'd5
  } kind_e;

  function automatic kind_e decode_kind(input logic [CODE_W-1:0] code);
    case (code)
      4'h0:    return K_CONFIG;
      4'h1:    return K_COEF;
      4'h4:    return K_SELECT;
      4'h8:    return K_ROUND;
      4'hC:    return K_LIMIT;
      default: return K_NONE;
    endcase
  endfunction

  function automatic int words_for(input kind_e k);
    case (k)
      K_COEF:           return TAPS;
      K_ROUND, K_LIMIT: return BYTE_GRP;
      K_CONFIG, K_SELECT: return 1;
      default:          return 0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] place_word(input logic [DATA_W-1:0] acc,
                                                   input kind_e k,
                                                   input logic [CNT_W-1:0] slot,
                                                   input logic [WORD_W-1:0] w);
    logic [DATA_W-1:0] r;
    r = acc;
    case (k)
      K_COEF:           r[int'(slot)*WORD_W +: WORD_W] = w;
      K_ROUND, K_LIMIT: r[int'(slot)*BYTE_W +: BYTE_W] = w[BYTE_W-1:0];
      default:          r[WORD_W-1:0] = w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cwl_decode.sv
module cwl_decode
  import cwl_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx,
  output logic              valid
);
  always_comb begin
    kind  = decode_kind(word[WORD_W-1 -: CODE_W]);
    idx   = word[IDX_W-1:0];
    valid = (kind != K_NONE);
  end
endmodule

// File: rtl/cwl_seq.sv
module cwl_seq
  import cwl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  kind_e            addr_kind,
  input  logic [IDX_W-1:0] addr_idx,
  input  logic             addr_valid,
  output logic             take_data,
  output logic             clear_stage,
  output logic             commit_now,
  output logic             err_now,
  output logic [CNT_W-1:0] slot,
  output kind_e            kind_q,
  output logic [IDX_W-1:0] idx_q
);
  logic in_data;
  logic skip;
  logic accept_addr;
  logic last_word;

  always_comb begin
    accept_addr = !ld_n && !in_data && !skip;
    take_data   = !ld_n && in_data;
    last_word   = take_data && (int'(slot) == words_for(kind_q) - 1);
    commit_now  = last_word;
    err_now     = accept_addr && !addr_valid;
    clear_stage = accept_addr && addr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= 1'b0;
      skip    <= 1'b0;
      slot    <= '0;
      kind_q  <= K_NONE;
      idx_q   <= '0;
    end else if (ld_n) begin
      in_data <= 1'b0;
      skip    <= 1'b0;
      slot    <= '0;
    end else if (accept_addr) begin
      slot <= '0;
      if (addr_valid) begin
        in_data <= 1'b1;
        kind_q  <= addr_kind;
        idx_q   <= addr_idx;
      end else begin
        skip <= 1'b1;
      end
    end else if (take_data) begin
      if (last_word) begin
        in_data <= 1'b0;
        slot    <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (int'(slot) < words_for(kind_q)));
  assert_addr_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_now |=> (!in_data && !skip));
  assert_skip_no_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !take_data);
endmodule

// File: rtl/cwl_stage.sv
module cwl_stage
  import cwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_stage,
  input  logic              take_data,
  input  logic              commit_now,
  input  kind_e             kind_q,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [CNT_W-1:0]  slot,
  input  logic [WORD_W-1:0] word,
  output logic              wr_stb,
  output logic [2:0]        wr_kind,
  output logic [IDX_W-1:0]  wr_index,
  output logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] acc_nxt;

  always_comb acc_nxt = place_word(acc, kind_q, slot, word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      wr_stb   <= 1'b0;
      wr_kind  <= '0;
      wr_index <= '0;
      wr_data  <= '0;
    end else begin
      if (clear_stage)    acc <= '0;
      else if (take_data) acc <= acc_nxt;
      wr_stb <= commit_now;
      if (commit_now) begin
        wr_data  <= acc_nxt;
        wr_kind  <= kind_q;
        wr_index <= idx_q;
      end
    end
  end

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_known_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_kind != 3'd0));
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic [WORD_W-1:0] bus_word,
  output logic              wr_stb,
  output logic [2:0]        wr_kind,
  output logic [IDX_W-1:0]  wr_index,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_stb
);
  kind_e             addr_kind;
  logic [IDX_W-1:0]  addr_idx;
  logic              addr_valid;
  logic              take_data;
  logic              clear_stage;
  logic              commit_now;
  logic              err_now;
  logic [CNT_W-1:0]  slot;
  kind_e             kind_q;
  logic [IDX_W-1:0]  idx_q;

  cwl_decode u_dec (
    .word(bus_word), .kind(addr_kind), .idx(addr_idx), .valid(addr_valid)
  );

  cwl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n),
    .addr_kind(addr_kind), .addr_idx(addr_idx), .addr_valid(addr_valid),
    .take_data(take_data), .clear_stage(clear_stage), .commit_now(commit_now),
    .err_now(err_now), .slot(slot), .kind_q(kind_q), .idx_q(idx_q)
  );

  cwl_stage u_stage (
    .clk(clk), .rst_n(rst_n), .clear_stage(clear_stage), .take_data(take_data),
    .commit_now(commit_now), .kind_q(kind_q), .idx_q(idx_q), .slot(slot),
    .word(bus_word), .wr_stb(wr_stb), .wr_kind(wr_kind), .wr_index(wr_index),
    .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_stb <= 1'b0;
    else        err_stb <= err_now;
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> !wr_stb);
  assert_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> !wr_stb);
  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |=> !err_stb);
endmodule

// File: tb/cfg_word_loader_bench.sv
module cfg_word_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_n = 1'b1;
  logic [11:0] bus_word = '0;
  logic        wr_stb;
  logic [2:0]  wr_kind;
  logic [7:0]  wr_index;
  logic [95:0] wr_data;
  logic        err_stb;

  int n_tests = 0;
  int n_fail  = 0;
  logic [11:0] wv [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_word_loader u_cfg_word_loader (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .bus_word(bus_word),
    .wr_stb(wr_stb), .wr_kind(wr_kind), .wr_index(wr_index),
    .wr_data(wr_data), .err_stb(err_stb)
  );

  task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int len_of(input logic [3:0] code);
    case (code)
      4'h1: return 8;
      4'h8, 4'hC: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [2:0] kind_of(input logic [3:0] code);
    case (code)
      4'h0: return 3'd1;
      4'h1: return 3'd2;
      4'h4: return 3'd3;
      4'h8: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [95:0] expect_data(input logic [3:0] code);
    logic [95:0] e = '0;
    if (code == 4'h1)
      for (int k = 7; k >= 0; k--) e = (e << 12) | 96'(wv[k]);
    else if (code == 4'h8 || code == 4'hC)
      for (int k = 3; k >= 0; k--) e = (e << 8) | 96'(wv[k][7:0]);
    else
      e = 96'(wv[0]);
    return e;
  endfunction

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'h1: return "R4";
      4'h8: return "R5/R8";
      4'hC: return "R6/R8";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic l, input logic [11:0] w);
    @(negedge clk);
    ld_n = l;
    bus_word = w;
    @(posedge clk);
    #1;
  endtask

  task automatic run_group(input logic [3:0] code, input logic [7:0] idx, input int abort_at);
    int n = len_of(code);
    step(1'b0, {code, idx});
    check("R11 no err on valid addr", 96'(err_stb), 96'd0);
    for (int i = 0; i < n; i++) begin
      if (i == abort_at) begin
        step(1'b1, 12'($urandom));
        check("R10 abort no strobe", 96'(wr_stb), 96'd0);
        return;
      end
      step(1'b0, wv[i]);
      if (i < n - 1) begin
        check("R12 no early strobe", 96'(wr_stb), 96'd0);
      end else begin
        check("R3 strobe on last", 96'(wr_stb), 96'd1);
        check("R2 kind", 96'(wr_kind), 96'(kind_of(code)));
        check("R2 index", 96'(wr_index), 96'(idx));
        check(req_of(code), wr_data, expect_data(code));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] codes [5];
    void'($urandom(32'h5EED_1234));
    codes[0] = 4'h0; codes[1] = 4'h1; codes[2] = 4'h4; codes[3] = 4'h8; codes[4] = 4'hC;
    repeat (3) @(posedge clk);
    #1;
    check("R1 stb", 96'(wr_stb), 96'd0);
    check("R1 err", 96'(err_stb), 96'd0);
    check("R1 data", wr_data, 96'd0);
    check("R1 kind/index", {85'd0, wr_kind, wr_index}, 96'd0);
    rst_n = 1'b1;

    // R10: bus noise while idle
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 12'($urandom));
      check("R10 idle strobe", 96'({wr_stb, err_stb}), 96'd0);
    end

    // R6: limit entry 7 example
    wv[0] = 12'h060; wv[1] = 12'h03B; wv[2] = 12'h0A4; wv[3] = 12'h072;
    run_group(4'hC, 8'h07, -1);
    check("R6 example", wr_data, 96'h72A43B60);
    // R9: back-to-back select, no gap
    wv[0] = 12'h00F;
    run_group(4'h4, 8'h02, -1);
    // R8: reserved nibble set on round data
    wv[0] = 12'hFA2; wv[1] = 12'h5F4; wv[2] = 12'h983; wv[3] = 12'h376;
    run_group(4'h8, 8'h0C, -1);
    check("R8 reserved ignored", wr_data, 96'h7683F4A2);
    // R4: coefficient bank back to back
    for (int k = 0; k < 8; k++) wv[k] = 12'(12'h101 * (k + 1));
    run_group(4'h1, 8'hFF, -1);
    step(1'b1, 12'h000);

    // R10: abort a coefficient group, then round commits cleanly
    for (int k = 0; k < 8; k++) wv[k] = 12'hABC;
    run_group(4'h1, 8'h10, 5);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 12'($urandom));
      check("R10 discard stays quiet", 96'(wr_stb), 96'd0);
    end
    wv[0] = 12'h011; wv[1] = 12'h022; wv[2] = 12'h033; wv[3] = 12'h044;
    run_group(4'h8, 8'h03, -1);

    // R11: unknown kind, then data words skipped
    step(1'b0, 12'h705);
    check("R11 err pulse", 96'(err_stb), 96'd1);
    for (int i = 0; i < 10; i++) begin
      step(1'b0, (i == 2) ? 12'hC01 : 12'($urandom));
      check("R11 skip no write/err", 96'({wr_stb, err_stb}), 96'd0);
    end
    step(1'b1, 12'h000);
    wv[0] = 12'h003;
    run_group(4'h0, 8'h02, -1);

    // random groups, back to back with occasional gaps (R3, R9)
    for (int g = 0; g < 80; g++) begin
      logic [3:0] c = codes[$urandom_range(0, 4)];
      for (int k = 0; k < 8; k++) wv[k] = 12'($urandom);
      run_group(c, 8'($urandom), ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 3)) : -1);
      if ($urandom_range(0, 3) == 0) step(1'b1, 12'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule